// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM from a three-wire serial audio link (a word-select line, a bit clock and a data line) and turns it into parallel left and right samples. A 3-bit format input chooses one of seven framings at run time: two I²S variants (24-bit and 16-bit payload), a left-justified framing with up to 24 bits, and right-justified framings carrying 24, 20, 18 or 16 bits. In the right-justified framings the word ends on the last bit before the next word-select edge, so where the MSB lands depends on both the word width and the number of bit clocks in each half-frame.

All logic runs on one fast system clock that oversamples the three link wires. The wires are synchronised, and a data bit is taken on every detected rising edge of the bit clock. Every sample is delivered MSB-aligned in a 24-bit word, with zeros below the last valid bit. A one-cycle strobe marks each complete stereo frame. Volume, filtering, conversion and the register access that sets the format are handled elsewhere.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high, and after it is released until the first strobe, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: Format code 0 (I²S, 24-bit): the first bit after a word-select transition is ignored, and the next 24 bits form the sample, MSB first. Word select low marks the left channel. If a half-frame carries fewer bits, the missing low bits are zero. Bits after the 24th are ignored.
- R3: Format code 1 (I²S, 16-bit): framing as in R2, but only 16 bits are taken. They land in output bits 23..8, bits 7..0 are zero, and later bits are ignored.
- R4: Format code 2 (left-justified): the first bit after a word-select transition is the MSB, and word select high marks the left channel. Up to 24 bits are taken, missing low bits are zero, and later bits are ignored.
- R5: Format codes 3, 4, 5 and 6 (right-justified, widths 24, 20, 18 and 16): the last N bits before the next word-select transition form the sample, with the final bit as LSB. Word select high marks the left channel. Earlier bits are ignored. The sample is output in bits 23 down to 24−N, with zeros below. If a half-frame has fewer than N bits, the missing leading bits are zero.
- R6: Format code 7 behaves exactly like format code 0.
- R7: `valid_o` pulses for exactly one cycle per stereo frame, after the right half-frame ends (marked by the next word-select transition). The outputs it qualifies are the left and right samples of the same frame.
- R8: After reset, no strobe is issued for a frame unless both of its half-frames started at a word-select transition seen after reset. A partial half-frame, or a right half-frame without a full left half before it, produces no strobe.
- R9: `left_o` and `right_o` change only in the cycle in which `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the link |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 3 | Framing select, codes 0..7 |
| lrck | input | 1 | Word-select line of the link (asynchronous) |
| sclk | input | 1 | Bit clock of the link (asynchronous) |
| sdata | input | 1 | Serial data, MSB first (asynchronous) |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe per stereo frame |

## Verification
The bench varies the number of bit clocks per half-frame from 16 to 64. This covers half-frames shorter than the word, where a design that does not pad would leak stale bits into the low end. It also covers half-frames much longer than the word, where a design that does not truncate right-justified data from the front would misplace the MSB, or would let trailing bits overwrite a left-justified sample. Each run starts with a partial half-frame, and some start with a left stub followed by an orphan right half, so a receiver that emits a frame before a full period has been seen delivers an extra, garbled strobe. The one-bit offset of the I²S framings and the inverted channel polarity are exercised on every frame, because a mistake in either swaps channels or shifts every sample by one bit.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam logic [2:0] FMT_I2S24 = 3'd0;
  localparam logic [2:0] FMT_I2S16 = 3'd1;
  localparam logic [2:0] FMT_LJ24  = 3'd2;
  localparam logic [2:0] FMT_RJ24  = 3'd3;
  localparam logic [2:0] FMT_RJ20  = 3'd4;
  localparam logic [2:0] FMT_RJ18  = 3'd5;
  localparam logic [2:0] FMT_RJ16  = 3'd6;

  // right-justified framings are codes 3..6
  function automatic logic fmt_is_rj(input logic [2:0] f);
    return (f >= FMT_RJ24) && (f <= FMT_RJ16);
  endfunction

  // I2S framings: codes 0, 1 and the reserved code 7
  function automatic logic fmt_is_i2s(input logic [2:0] f);
    return !fmt_is_rj(f) && (f != FMT_LJ24);
  endfunction

  function automatic int fmt_rj_width(input logic [2:0] f);
    case (f)
      FMT_RJ24: return 24;
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      default:  return 16;
    endcase
  endfunction

  // number of bits kept for MSB-first framings
  function automatic int fmt_lead_limit(input logic [2:0] f);
    return (f == FMT_I2S16) ? 16 : 24;
  endfunction

  // bit clocks between the word-select edge and the MSB
  function automatic int fmt_lead_offset(input logic [2:0] f);
    return fmt_is_i2s(f) ? 1 : 0;
  endfunction

  // word-select level that marks the left channel
  function automatic logic fmt_left_level(input logic [2:0] f);
    return !fmt_is_i2s(f);
  endfunction

endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lrck_i,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic bit_stb,
  output logic lrck_q,
  output logic sdata_q
);
  localparam int LAST = STAGES - 1;

  // bit 2: word select, bit 1: bit clock, bit 0: data
  logic [STAGES-1:0][2:0] pipe;
  logic                   sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= {lrck_i, sclk_i, sdata_i};
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  // strobe, word select and data leave this stage together
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      bit_stb   <= 1'b0;
      lrck_q    <= 1'b0;
      sdata_q   <= 1'b0;
    end else begin
      sclk_prev <= pipe[LAST][1];
      bit_stb   <= pipe[LAST][1] & ~sclk_prev;
      lrck_q    <= pipe[LAST][2];
      sdata_q   <= pipe[LAST][0];
    end
  end

  // R7: a bit strobe can never last two cycles
  a_r7_strobe_isolated: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/sar_deframer.sv
module sar_deframer
  import sar_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              lrck_q,
  input  logic              sdata_q,
  input  logic [2:0]        fmt,
  output logic              half_done,
  output logic              half_left,
  output logic [WORD_W-1:0] half_word,
  output logic [1:0]        edges_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic              have_ref;
  logic              lrck_last;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] lead_acc, lead_next;
  logic [WORD_W-1:0] tail_sr, tail_next;
  logic [WORD_W-1:0] done_word;
  logic              new_half;
  int                pos;

  assign new_half = bit_stb && have_ref && (lrck_q != lrck_last);

  // MSB-first placement and right-justified shifting of the current bit
  always_comb begin
    lead_next = new_half ? '0 : lead_acc;
    pos = (new_half ? 0 : int'(idx)) - fmt_lead_offset(fmt);
    if (pos >= 0 && pos < fmt_lead_limit(fmt)) begin
      for (int b = 0; b < WORD_W; b++)
        if (pos == WORD_W - 1 - b) lead_next[b] = sdata_q;
    end
    tail_next = new_half ? {{(WORD_W-1){1'b0}}, sdata_q}
                         : {tail_sr[WORD_W-2:0], sdata_q};
  end

  // word of the half-frame that ends at this transition
  always_comb begin
    if (fmt_is_rj(fmt)) done_word = tail_sr << (WORD_W - fmt_rj_width(fmt));
    else                done_word = lead_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_ref   <= 1'b0;
      lrck_last  <= 1'b0;
      idx        <= '0;
      lead_acc   <= '0;
      tail_sr    <= '0;
      half_done  <= 1'b0;
      half_left  <= 1'b0;
      half_word  <= '0;
      edges_seen <= '0;
    end else begin
      half_done <= 1'b0;
      if (bit_stb) begin
        have_ref  <= 1'b1;
        lrck_last <= lrck_q;
        lead_acc  <= lead_next;
        tail_sr   <= tail_next;
        if (new_half) begin
          idx        <= CNT_ONE;
          half_done  <= 1'b1;
          half_left  <= (lrck_last == fmt_left_level(fmt));
          half_word  <= done_word;
          if (edges_seen != 2'd3) edges_seen <= edges_seen + 2'd1;
        end else if (idx != CNT_MAX) begin
          idx <= idx + CNT_ONE;
        end
      end
    end
  end

  // R8: the transition count never goes back between resets
  a_r8_edges_monotonic: assert property (@(posedge clk) disable iff (rst)
    edges_seen >= $past(edges_seen));

  // R7: a half-frame ends only on a bit strobe that sees a new level
  a_r7_done_on_edge: assert property (@(posedge clk) disable iff (rst)
    half_done |-> $past(bit_stb) && ($past(lrck_q) != lrck_last || idx == CNT_ONE));

endmodule

// File: rtl/sar_frame_out.sv
module sar_frame_out #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_done,
  input  logic              half_left,
  input  logic [WORD_W-1:0] half_word,
  input  logic [1:0]        edges_seen,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] left_hold;
  logic              have_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (half_done) begin
        if (half_left) begin
          left_hold <= half_word;
          have_left <= 1'b1;
        end else begin
          have_left <= 1'b0;
          // left began at transition 1 or later: both halves are full
          if (have_left && edges_seen == 2'd3) begin
            left_o  <= left_hold;
            right_o <= half_word;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  // R7: single-cycle strobe, raised only after a right half-frame
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  a_r7_after_right: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(half_done) && !$past(half_left));

  // R8: no strobe before a full period has been seen
  a_r8_full_period: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> edges_seen == 2'd3);

  // R9: samples hold between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(left_o) && $stable(right_o));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  fmt_sel,
  input  logic        lrck,
  input  logic        sclk,
  input  logic        sdata,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);
  localparam int WORD_W = 24;

  logic              bit_stb, lrck_q, sdata_q;
  logic              half_done, half_left;
  logic [WORD_W-1:0] half_word;
  logic [1:0]        edges_seen;

  sar_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .lrck_i(lrck), .sclk_i(sclk), .sdata_i(sdata),
    .bit_stb(bit_stb), .lrck_q(lrck_q), .sdata_q(sdata_q)
  );

  sar_deframer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_deframe (
    .clk(clk), .rst(rst),
    .bit_stb(bit_stb), .lrck_q(lrck_q), .sdata_q(sdata_q), .fmt(fmt_sel),
    .half_done(half_done), .half_left(half_left), .half_word(half_word),
    .edges_seen(edges_seen)
  );

  sar_frame_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst(rst),
    .half_done(half_done), .half_left(half_left), .half_word(half_word),
    .edges_seen(edges_seen),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt = 3'd0;
  logic        lrck = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, failures = 0, got = 0;
  bit finished = 0;
  bit prev_valid = 0, hold_bad = 0;
  logic [23:0] last_l = '0, last_r = '0;
  logic [23:0] q_l[$], q_r[$];
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst(rst), .fmt_sel(fmt), .lrck(lrck), .sclk(sclk), .sdata(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  // expected sample: s[i] is the i-th bit sent in a half-frame of n bits
  function automatic logic [23:0] model(input logic [2:0] f, input logic [63:0] s, input int n);
    logic [23:0] w = '0;
    if (f >= 3 && f <= 6) begin
      int rw = (f == 3) ? 24 : (f == 4) ? 20 : (f == 5) ? 18 : 16;
      for (int p = 0; p < rw; p++) begin
        int i = n - rw + p;
        if (i >= 0) w[23-p] = s[i];
      end
    end else begin
      int off = (f == 2) ? 0 : 1;
      int lim = (f == 1) ? 16 : 24;
      for (int p = 0; p < lim; p++) begin
        int i = off + p;
        if (i < n) w[23-p] = s[i];
      end
    end
    return w;
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd7: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (valid_o && prev_valid) begin
        checks++; failures++;
        $display("FAIL R7 strobe longer than one cycle actual=2 expected=1");
      end
      if (valid_o) begin
        got++;
        if (q_l.size() == 0) begin
          checks++; failures++;
          $display("FAIL R8 unexpected strobe actual=%h/%h expected=none", left_o, right_o);
        end else begin
          check(cur_req, "left", left_o, q_l.pop_front());
          check(cur_req, "right", right_o, q_r.pop_front());
        end
      end else if (left_o !== last_l || right_o !== last_r) begin
        hold_bad = 1;
      end
      last_l = left_o; last_r = right_o; prev_valid = valid_o;
    end
  end

  task automatic send_bit(input logic lv, input logic b);
    @(negedge clk);
    sclk = 1'b0; lrck = lv; sdata = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(input logic lv, input logic [63:0] s, input int n);
    for (int i = 0; i < n; i++) send_bit(lv, s[i]);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic run(input logic [2:0] f, input int frames, input bit orphan);
    logic lv_left = (f == 3'd2 || (f >= 3'd3 && f <= 3'd6));
    @(negedge clk);
    rst = 1'b1; fmt = f; sclk = 1'b0; lrck = ~lv_left; sdata = 1'b0;
    q_l.delete(); q_r.delete();
    repeat (6) @(negedge clk);
    check("R1", "left in reset", left_o, 24'h0);
    check("R1", "right in reset", right_o, 24'h0);
    check("R1", "valid in reset", {23'h0, valid_o}, 24'h0);
    cur_req = req_of(f); got = 0; hold_bad = 0; prev_valid = 0;
    last_l = '0; last_r = '0;
    rst = 1'b0;
    repeat (4) @(negedge clk);
    if (orphan) begin
      // R8: left stub then an orphan right half must produce no strobe
      send_half(lv_left, rnd64(), 5);
      send_half(~lv_left, rnd64(), 32);
    end else begin
      send_half(~lv_left, rnd64(), 5);
    end
    check("R1", "left before first strobe", left_o, 24'h0);
    for (int k = 0; k < frames; k++) begin
      int n = (k == 0) ? 64 : (k == 1) ? 24 : 16 + int'($urandom % 49);
      logic [63:0] sl = rnd64(), sr = rnd64();
      q_l.push_back(model(f, sl, n));
      q_r.push_back(model(f, sr, n));
      send_half(lv_left, sl, n);
      send_half(~lv_left, sr, n);
    end
    send_half(lv_left, rnd64(), 3);
    repeat (30) @(negedge clk);
    check(orphan ? "R8" : "R7", "strobe count", 24'(got), 24'(frames));
    checks++;
    if (hold_bad) begin
      failures++;
      $display("FAIL R9 outputs moved without strobe actual=1 expected=0");
    end
  endtask

  initial begin
    void'($urandom(32'd4341));
    for (int f = 0; f < 8; f++) run(3'(f), 6, 1'b0);
    run(3'd0, 4, 1'b1);
    run(3'd3, 4, 1'b1);
    run(3'd2, 4, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule